// File: doc/BRIEF.md
# Setpoint Clock Gate Controller

This block produces one registered gate-enable per gated clock, intended to feed an integrated clock-gating cell. Each clock carries its own control state. In software mode the gate follows a direct on/off bit. In domain-owned mode it still follows that bit, but only whitelisted domains may change the clock's settings. In setpoint mode the gate is looked up from a 16-entry run mask, indexed by the system setpoint, and trimmed by a 16-entry standby mask while standby is asserted. In CPU-low-power mode the gate follows the direct bit, but drops while any whitelisted domain reports its CPU in low power.

Configuration uses a simple single-cycle write port, tagged with the writing domain, and a registered read port. Two set-only lock bits freeze the control mode and the whitelist until the next reset. A read-only capability flag tells software whether setpoint control exists for a given clock. A request to enter setpoint mode on a clock without that capability is dropped.

Top module: `sp_clkgate_ctrl`

## Requirements
- R1: After reset every gate enable is 1. Every clock is in software mode (mode code 0) with the direct bit 1, both masks 16'hFFFF, the whitelist all ones, and both locks 0.
- R2: In software mode (code 0) the gate equals the direct bit (field 0, data bit 0). The setpoint, standby and CPU-low-power inputs have no effect on it.
- R3: In setpoint mode (code 2) with standby low, the gate equals bit n of the run mask (field 2), where n is the setpoint index.
- R4: In setpoint mode with standby high, the gate equals run-mask bit n AND standby-mask bit n (field 3).
- R5: A change on the setpoint, standby or low-power inputs reaches the gate after exactly two rising edges. A configuration write reaches the gate on the second edge counted from the write edge itself.
- R6: In any mode other than software mode, a write from a domain whose whitelist bit (field 4, bit d for domain d) is 0 is ignored. In software mode any domain may write.
- R7: Writing field 5 with data bit 0 set sets the mode lock. Once set, writes to the mode field (field 1, data bits 1:0) are ignored. Writing 0 to the lock does not clear it; only reset does.
- R8: Writing field 5 with data bit 1 set sets the whitelist lock. Once set, whitelist writes are ignored until reset. Field 5 reads back {bit1 whitelist lock, bit0 mode lock}.
- R9: Field 6 reads the read-only setpoint capability bit of the clock. A mode write selecting code 2 on a clock without the capability leaves the mode unchanged.
- R10: In CPU-low-power mode (code 3) the gate is the direct bit AND NOT (any domain that is both whitelisted and flagged on the low-power input).
- R11: In domain-owned mode (code 1) the gate equals the direct bit.
- R12: Read data for the selected clock and field appears one rising edge after the read select and read field inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| sp_idx | input | 4 | Current system setpoint index |
| standby | input | 1 | System standby indication |
| cpu_lowpwr | input | NUM_DOM | Per-domain CPU low-power flags |
| wr_en | input | 1 | Write strobe |
| wr_dom | input | DOM_W | Domain issuing the write |
| wr_sel | input | CLK_W | Clock targeted by the write |
| wr_field | input | 3 | Field code: 0 direct, 1 mode, 2 run mask, 3 standby mask, 4 whitelist, 5 locks |
| wr_data | input | 16 | Write data |
| rd_sel | input | CLK_W | Clock targeted by the read |
| rd_field | input | 3 | Field code for read (6 = capability) |
| rd_data | output | 16 | Registered read data, zero-extended |
| gate_en | output | NUM_CLK | Registered gate enable per clock |

## Verification
A corrupted mode register, mask bit or direct bit shows at `gate_en` on the second edge after the offending write, or after the setpoint or standby change that selects it. The only exception is a latent mask bit at a setpoint not yet visited. The bench walks many setpoint and standby combinations so that such bits are exposed. A wrong lock or whitelist bit is invisible until a later write should have been accepted or refused. For that reason the bench follows each refused write with a gate or read-back check one edge later.

// File: rtl/sp_clkgate_pkg.sv
package sp_clkgate_pkg;

  typedef enum logic [1:0] {
    CM_SOFTWARE = 2'd0,
    CM_DOMAIN   = 2'd1,
    CM_SETPOINT = 2'd2,
    CM_CPULP    = 2'd3
  } ctl_mode_e;

  localparam logic [2:0] FLD_DIRECT = 3'd0;
  localparam logic [2:0] FLD_MODE   = 3'd1;
  localparam logic [2:0] FLD_RUN    = 3'd2;
  localparam logic [2:0] FLD_STBY   = 3'd3;
  localparam logic [2:0] FLD_WLIST  = 3'd4;
  localparam logic [2:0] FLD_LOCK   = 3'd5;
  localparam logic [2:0] FLD_CAP    = 3'd6;

endpackage

// File: rtl/sp_cg_cfg_slot.sv
module sp_cg_cfg_slot
  import sp_clkgate_pkg::*;
#(
  parameter int NUM_SP  = 16,
  parameter int NUM_DOM = 4,
  parameter int DOM_W   = 2,
  parameter bit CAP     = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_hit,
  input  logic [DOM_W-1:0]   wr_dom,
  input  logic [2:0]         wr_field,
  input  logic [NUM_SP-1:0]  wr_data,
  output logic               direct_on,
  output ctl_mode_e          mode,
  output logic [NUM_SP-1:0]  run_mask,
  output logic [NUM_SP-1:0]  stby_mask,
  output logic [NUM_DOM-1:0] wlist,
  output logic               mode_lock,
  output logic               wl_lock
);

  logic      permitted;
  ctl_mode_e req_mode;
  logic      mode_ok;

  // software mode is open to every domain; other modes honour the whitelist
  assign permitted = wr_hit && ((mode == CM_SOFTWARE) || wlist[wr_dom]);
  assign req_mode  = ctl_mode_e'(wr_data[1:0]);
  assign mode_ok   = !mode_lock && ((req_mode != CM_SETPOINT) || CAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      direct_on <= 1'b1;
      mode      <= CM_SOFTWARE;
      run_mask  <= '1;
      stby_mask <= '1;
      wlist     <= '1;
      mode_lock <= 1'b0;
      wl_lock   <= 1'b0;
    end else if (permitted) begin
      case (wr_field)
        FLD_DIRECT: direct_on <= wr_data[0];
        FLD_MODE:   if (mode_ok) mode <= req_mode;
        FLD_RUN:    run_mask  <= wr_data;
        FLD_STBY:   stby_mask <= wr_data;
        FLD_WLIST:  if (!wl_lock) wlist <= wr_data[NUM_DOM-1:0];
        FLD_LOCK: begin
          mode_lock <= mode_lock | wr_data[0];
          wl_lock   <= wl_lock   | wr_data[1];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sp_cg_gate_eval.sv
module sp_cg_gate_eval
  import sp_clkgate_pkg::*;
#(
  parameter int NUM_SP  = 16,
  parameter int NUM_DOM = 4,
  parameter int SP_W    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SP_W-1:0]    sp_q,
  input  logic               stby_q,
  input  logic [NUM_DOM-1:0] lp_q,
  input  logic               direct_on,
  input  ctl_mode_e          mode,
  input  logic [NUM_SP-1:0]  run_mask,
  input  logic [NUM_SP-1:0]  stby_mask,
  input  logic [NUM_DOM-1:0] wlist,
  output logic               gate
);

  logic gate_nxt;

  always_comb begin
    case (mode)
      CM_SETPOINT: gate_nxt = run_mask[sp_q] & (~stby_q | stby_mask[sp_q]);
      CM_CPULP:    gate_nxt = direct_on & ~(|(lp_q & wlist));
      default:     gate_nxt = direct_on;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) gate <= 1'b1;
    else     gate <= gate_nxt;
  end

endmodule

// File: rtl/sp_clkgate_ctrl.sv
module sp_clkgate_ctrl
  import sp_clkgate_pkg::*;
#(
  parameter int                  NUM_CLK = 4,
  parameter int                  NUM_SP  = 16,
  parameter int                  NUM_DOM = 4,
  parameter logic [NUM_CLK-1:0]  SP_CAP  = 4'b1011,
  localparam int                 SP_W    = $clog2(NUM_SP),
  localparam int                 DOM_W   = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1,
  localparam int                 CLK_W   = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1,
  localparam int                 DATA_W  = NUM_SP
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SP_W-1:0]    sp_idx,
  input  logic               standby,
  input  logic [NUM_DOM-1:0] cpu_lowpwr,
  input  logic               wr_en,
  input  logic [DOM_W-1:0]   wr_dom,
  input  logic [CLK_W-1:0]   wr_sel,
  input  logic [2:0]         wr_field,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [CLK_W-1:0]   rd_sel,
  input  logic [2:0]         rd_field,
  output logic [DATA_W-1:0]  rd_data,
  output logic [NUM_CLK-1:0] gate_en
);

  logic [SP_W-1:0]    sp_q;
  logic               stby_q;
  logic [NUM_DOM-1:0] lp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q   <= '0;
      stby_q <= 1'b0;
      lp_q   <= '0;
    end else begin
      sp_q   <= sp_idx;
      stby_q <= standby;
      lp_q   <= cpu_lowpwr;
    end
  end

  logic [NUM_CLK-1:0]   direct_v;
  ctl_mode_e            mode_a  [NUM_CLK];
  logic [NUM_SP-1:0]    run_a   [NUM_CLK];
  logic [NUM_SP-1:0]    stby_a  [NUM_CLK];
  logic [NUM_DOM-1:0]   wlist_a [NUM_CLK];
  logic [NUM_CLK-1:0]   mlock_v;
  logic [NUM_CLK-1:0]   wlock_v;
  logic [2*NUM_CLK-1:0] mode_flat;
  logic [NUM_CLK*NUM_DOM-1:0] wlist_flat;

  for (genvar g = 0; g < NUM_CLK; g++) begin : g_clk
    sp_cg_cfg_slot #(
      .NUM_SP(NUM_SP), .NUM_DOM(NUM_DOM), .DOM_W(DOM_W), .CAP(SP_CAP[g])
    ) u_slot (
      .clk       (clk),
      .rst       (rst),
      .wr_hit    (wr_en && (wr_sel == CLK_W'(g))),
      .wr_dom    (wr_dom),
      .wr_field  (wr_field),
      .wr_data   (wr_data),
      .direct_on (direct_v[g]),
      .mode      (mode_a[g]),
      .run_mask  (run_a[g]),
      .stby_mask (stby_a[g]),
      .wlist     (wlist_a[g]),
      .mode_lock (mlock_v[g]),
      .wl_lock   (wlock_v[g])
    );

    sp_cg_gate_eval #(
      .NUM_SP(NUM_SP), .NUM_DOM(NUM_DOM), .SP_W(SP_W)
    ) u_eval (
      .clk       (clk),
      .rst       (rst),
      .sp_q      (sp_q),
      .stby_q    (stby_q),
      .lp_q      (lp_q),
      .direct_on (direct_v[g]),
      .mode      (mode_a[g]),
      .run_mask  (run_a[g]),
      .stby_mask (stby_a[g]),
      .wlist     (wlist_a[g]),
      .gate      (gate_en[g])
    );

    assign mode_flat[2*g +: 2]             = mode_a[g];
    assign wlist_flat[NUM_DOM*g +: NUM_DOM] = wlist_a[g];
  end

  logic [DATA_W-1:0] rd_nxt;

  always_comb begin
    rd_nxt = '0;
    case (rd_field)
      FLD_DIRECT: rd_nxt[0]         = direct_v[rd_sel];
      FLD_MODE:   rd_nxt[1:0]       = mode_a[rd_sel];
      FLD_RUN:    rd_nxt            = run_a[rd_sel];
      FLD_STBY:   rd_nxt            = stby_a[rd_sel];
      FLD_WLIST:  rd_nxt[NUM_DOM-1:0] = wlist_a[rd_sel];
      FLD_LOCK:   rd_nxt[1:0]       = {wlock_v[rd_sel], mlock_v[rd_sel]};
      FLD_CAP:    rd_nxt[0]         = SP_CAP[rd_sel];
      default:    rd_nxt            = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_nxt;
  end

endmodule

// File: rtl/sp_clkgate_chk.sv
module sp_clkgate_chk #(
  parameter int                 NUM_CLK = 4,
  parameter int                 NUM_DOM = 4,
  parameter logic [NUM_CLK-1:0] SP_CAP  = '1
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NUM_CLK-1:0]         gate_en,
  input logic [NUM_CLK-1:0]         direct_v,
  input logic [2*NUM_CLK-1:0]       mode_flat,
  input logic [NUM_CLK-1:0]         mlock_v,
  input logic [NUM_CLK-1:0]         wlock_v,
  input logic [NUM_CLK*NUM_DOM-1:0] wlist_flat
);

  a_r1_gate_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (gate_en == '1));

  for (genvar i = 0; i < NUM_CLK; i++) begin : g_chk
    a_r2_software_follow: assert property (@(posedge clk) disable iff (rst)
      ($past(mode_flat[2*i +: 2]) == 2'd0) |-> (gate_en[i] == $past(direct_v[i])));

    a_r11_domain_follow: assert property (@(posedge clk) disable iff (rst)
      ($past(mode_flat[2*i +: 2]) == 2'd1) |-> (gate_en[i] == $past(direct_v[i])));

    a_r7_mode_lock_sticky: assert property (@(posedge clk) disable iff (rst)
      $past(mlock_v[i]) |-> mlock_v[i]);

    a_r7_mode_frozen: assert property (@(posedge clk) disable iff (rst)
      $past(mlock_v[i]) |-> $stable(mode_flat[2*i +: 2]));

    a_r8_wlist_lock_sticky: assert property (@(posedge clk) disable iff (rst)
      $past(wlock_v[i]) |-> wlock_v[i]);

    a_r8_wlist_frozen: assert property (@(posedge clk) disable iff (rst)
      $past(wlock_v[i]) |-> $stable(wlist_flat[NUM_DOM*i +: NUM_DOM]));

    if (!SP_CAP[i]) begin : g_nocap
      a_r9_no_setpoint_mode: assert property (@(posedge clk) disable iff (rst)
        mode_flat[2*i +: 2] != 2'd2);
    end
  end

endmodule

bind sp_clkgate_ctrl sp_clkgate_chk #(
  .NUM_CLK(NUM_CLK), .NUM_DOM(NUM_DOM), .SP_CAP(SP_CAP)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .gate_en    (gate_en),
  .direct_v   (direct_v),
  .mode_flat  (mode_flat),
  .mlock_v    (mlock_v),
  .wlock_v    (wlock_v),
  .wlist_flat (wlist_flat)
);

// File: tb/sp_clkgate_ctrl_tb.sv
module sp_clkgate_ctrl_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  sp_idx = '0;
  logic        standby = 1'b0;
  logic [3:0]  cpu_lowpwr = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_dom = '0;
  logic [1:0]  wr_sel = '0;
  logic [2:0]  wr_field = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [2:0]  rd_field = '0;
  logic [15:0] rd_data;
  logic [3:0]  gate_en;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  logic [15:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  sp_clkgate_ctrl u_dut (
    .clk(clk), .rst(rst), .sp_idx(sp_idx), .standby(standby),
    .cpu_lowpwr(cpu_lowpwr), .wr_en(wr_en), .wr_dom(wr_dom), .wr_sel(wr_sel),
    .wr_field(wr_field), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_field(rd_field), .rd_data(rd_data), .gate_en(gate_en)
  );

  // {expected gate of clock 0, standby, setpoint}; run 16'hA5C3, standby mask 16'h0FF0
  localparam logic [5:0] VEC [10] = '{
    6'b1_0_0000, 6'b0_0_0010, 6'b1_0_0110, 6'b0_1_0000, 6'b1_1_0110,
    6'b1_1_1000, 6'b1_0_1111, 6'b0_1_1111, 6'b0_1_1101, 6'b1_0_1010
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] dom, input logic [1:0] sel,
                    input logic [2:0] fld, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_dom = dom; wr_sel = sel; wr_field = fld; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [2:0] fld, output logic [15:0] v);
    @(negedge clk);
    rd_sel = sel; rd_field = fld;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    chk("R1 gate after reset", {12'd0, gate_en}, 16'h000F);
    rd(2'd0, 3'd1, rv); chk("R1 mode", rv, 16'h0000);
    rd(2'd1, 3'd2, rv); chk("R1 run mask", rv, 16'hFFFF);
    rd(2'd2, 3'd3, rv); chk("R1 standby mask", rv, 16'hFFFF);
    rd(2'd3, 3'd5, rv); chk("R1 locks", rv, 16'h0000);
    rd(2'd3, 3'd4, rv); chk("R1 whitelist", rv, 16'h000F);

    // R2 software mode ignores setpoint / standby / low power
    sp_idx = 4'd5; standby = 1'b1; cpu_lowpwr = 4'hF;
    settle();
    chk("R2 inputs ignored", {12'd0, gate_en}, 16'h000F);
    standby = 1'b0; cpu_lowpwr = 4'h0;
    wr(2'd2, 2'd1, 3'd0, 16'h0000);
    wr(2'd1, 2'd3, 3'd0, 16'h0000);
    @(negedge clk);
    chk("R2 direct off", {12'd0, gate_en}, 16'h0005);

    // R9 capability
    rd(2'd2, 3'd6, rv); chk("R9 cap clock2", rv, 16'h0000);
    rd(2'd0, 3'd6, rv); chk("R9 cap clock0", rv, 16'h0001);
    wr(2'd0, 2'd2, 3'd0, 16'h0000);
    wr(2'd0, 2'd2, 3'd1, 16'h0002);
    rd(2'd2, 3'd1, rv); chk("R9 setpoint refused", rv, 16'h0000);
    chk("R9 gate still direct", {15'd0, gate_en[2]}, 16'h0000);
    wr(2'd0, 2'd2, 3'd0, 16'h0001);

    // R3/R4 table walk on clock 0
    wr(2'd0, 2'd0, 3'd2, 16'hA5C3);
    wr(2'd0, 2'd0, 3'd3, 16'h0FF0);
    wr(2'd0, 2'd0, 3'd1, 16'h0002);
    for (int i = 0; i < 10; i++) begin
      sp_idx = VEC[i][3:0]; standby = VEC[i][4];
      settle();
      chk(VEC[i][4] ? "R4 standby lookup" : "R3 run lookup",
          {15'd0, gate_en[0]}, {15'd0, VEC[i][5]});
      chk("R2 clock3 unaffected", {15'd0, gate_en[3]}, 16'h0000);
    end

    // R5 latency of input path
    standby = 1'b0; sp_idx = 4'd2;
    settle();
    chk("R5 sp2 gate low", {15'd0, gate_en[0]}, 16'h0000);
    sp_idx = 4'd0;
    @(negedge clk);
    chk("R5 one edge unchanged", {15'd0, gate_en[0]}, 16'h0000);
    @(negedge clk);
    chk("R5 two edges changed", {15'd0, gate_en[0]}, 16'h0001);
    sp_idx = 4'd2;
    settle();
    // R5 latency of config path
    wr(2'd0, 2'd0, 3'd2, 16'hA5C7);
    chk("R5 write edge unchanged", {15'd0, gate_en[0]}, 16'h0000);
    @(negedge clk);
    chk("R5 write second edge", {15'd0, gate_en[0]}, 16'h0001);

    // R6/R11 whitelist on clock 1 (direct currently 0)
    wr(2'd3, 2'd1, 3'd4, 16'h0001);
    wr(2'd0, 2'd1, 3'd1, 16'h0001);
    wr(2'd2, 2'd1, 3'd0, 16'h0001);
    @(negedge clk);
    chk("R6 foreign write ignored", {15'd0, gate_en[1]}, 16'h0000);
    rd(2'd1, 3'd0, rv); chk("R6 direct unchanged", rv, 16'h0000);
    wr(2'd0, 2'd1, 3'd0, 16'h0001);
    @(negedge clk);
    chk("R11 owner write follows", {15'd0, gate_en[1]}, 16'h0001);

    // R10 CPU low-power mode
    wr(2'd0, 2'd1, 3'd1, 16'h0003);
    cpu_lowpwr = 4'b0010;
    settle();
    chk("R10 non-listed domain", {15'd0, gate_en[1]}, 16'h0001);
    cpu_lowpwr = 4'b0001;
    settle();
    chk("R10 listed domain asleep", {15'd0, gate_en[1]}, 16'h0000);
    cpu_lowpwr = 4'b0000;
    settle();
    chk("R10 awake again", {15'd0, gate_en[1]}, 16'h0001);

    // R8 whitelist lock
    wr(2'd0, 2'd1, 3'd5, 16'h0002);
    wr(2'd0, 2'd1, 3'd4, 16'h000F);
    rd(2'd1, 3'd4, rv); chk("R8 whitelist frozen", rv, 16'h0001);

    // R7 mode lock
    wr(2'd0, 2'd1, 3'd5, 16'h0001);
    wr(2'd0, 2'd1, 3'd1, 16'h0000);
    rd(2'd1, 3'd1, rv); chk("R7 mode frozen", rv, 16'h0003);
    wr(2'd0, 2'd1, 3'd5, 16'h0000);
    rd(2'd1, 3'd5, rv); chk("R7 locks set-only", rv, 16'h0003);

    // R12 read latency
    @(negedge clk);
    rd_sel = 2'd0; rd_field = 3'd2;
    #1;
    chk("R12 read not yet updated", rd_data, 16'h0003);
    @(negedge clk);
    chk("R12 read after one edge", rd_data, 16'hA5C7);

    // R1/R7 reset clears locks
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd(2'd1, 3'd5, rv); chk("R1 locks cleared by reset", rv, 16'h0000);
    rd(2'd1, 3'd1, rv); chk("R1 mode cleared by reset", rv, 16'h0000);
    chk("R1 gates after second reset", {12'd0, gate_en}, 16'h000F);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule